// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block keeps a small character store for a multiplexed digit display and steps through it without further help from the host. A scan counter selects one digit at a time and shows that digit's stored byte on two 4-bit output ports. The upper nibble goes to port A and the lower nibble to port B. The two ports can carry one 8-bit glyph, or two independent 4-bit displays whose halves the host updates separately. Each digit stays selected for a fixed number of clocks. Around every change of digit a blank window forces a host-chosen blank code onto the outputs, so the previous glyph does not ghost onto the next digit.

The host writes through a one-cycle command port and a one-cycle write port. A command sets the write pointer and chooses whether the pointer advances after each write. A configuration input sets the number of digits in the scan, either the full store or half of it. Another input picks how characters are placed. In left-placed entry each byte goes to the pointer location. In right-placed entry each new byte enters at the highest active position and the older ones move down by one place.

Top module: `disp_refresh`

## Requirements
- R1: While reset is asserted, and for two clocks after it is released, every store entry reads zero, the write pointer is 0 with advance off, the scan index is 0, `blank_o` is 1 and the outputs show `blank_code`.
- R2: The scan index holds for DWELL clocks and then goes up by one. It returns to 0 after the last active digit: digit 15 when `cfg_sixteen`=1, digit 7 when it is 0. If the index is above the last active digit when the digit period ends, it goes to 0.
- R3: `blank_o` is 1 during the first BLANK_CYC and the last BLANK_CYC clocks of every digit period, and 0 in the clocks between them.
- R4: While `blank_o` is 1, `out_a` shows `blank_code[7:4]` and `out_b` shows `blank_code[3:0]`.
- R5: While `blank_o` is 0, `out_a` and `out_b` show the upper and lower nibble of the store entry at the scan index.
- R6: A command loads the write pointer from `cmd_addr` and loads the advance flag from `cmd_autoinc`. In 8-digit mode bit 3 of the pointer is forced to 0. A write presented in the same cycle as a command is dropped.
- R7: In left-placed entry (`cfg_right`=0) a write stores the byte at the pointer. When the advance flag is set, the pointer then goes up by one and wraps from the last active digit to 0. When the flag is clear, the pointer stays where it is.
- R8: In left-placed entry, `wr_keep_hi`=1 leaves the upper nibble of the entry unchanged and `wr_keep_lo`=1 leaves the lower nibble unchanged.
- R9: In right-placed entry (`cfg_right`=1) each active entry i below the last takes the old value of entry i+1, and the last active entry takes the new byte. Entries above the active range, the pointer and the keep inputs have no effect on this write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_sixteen | input | 1 | 1: scan 16 digits, 0: scan 8 digits |
| cfg_right | input | 1 | 1: right-placed entry, 0: left-placed entry |
| blank_code | input | 8 | Byte shown during blank windows |
| cmd_valid | input | 1 | Load the write pointer this cycle |
| cmd_addr | input | 4 | Pointer value to load |
| cmd_autoinc | input | 1 | Advance flag loaded with the pointer |
| wr_valid | input | 1 | Write a character this cycle |
| wr_data | input | 8 | Character byte |
| wr_keep_hi | input | 1 | Keep the upper nibble on a left-placed write |
| wr_keep_lo | input | 1 | Keep the lower nibble on a left-placed write |
| scan_o | output | 4 | Binary index of the digit being driven |
| blank_o | output | 1 | Blank window indicator |
| out_a | output | 4 | Upper nibble of the shown byte |
| out_b | output | 4 | Lower nibble of the shown byte |

## Verification
The bench builds the block with its default parameters: a 16-entry store of bytes, an 8-clock digit period and a 2-clock blank window on each side of a digit change. With these values a full 16-digit scan takes only 128 clocks. The bench can therefore sweep every digit several times after each phase of stimulus, write and read back all sixteen addresses one by one, and switch between 8 and 16 digits while the scan is in the upper half. A cycle model in the bench predicts the index, the blank window and both nibble ports on every clock.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic {
    ENTRY_LEFT  = 1'b0,
    ENTRY_RIGHT = 1'b1
  } entry_e;

  // index of the last active digit for the selected scan length
  function automatic int last_digit(input logic sixteen, input int depth);
    return sixteen ? depth - 1 : depth / 2 - 1;
  endfunction
endpackage

// File: rtl/disp_addr.sv
module disp_addr
  import disp_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sixteen,
  input  entry_e        entry_mode,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_autoinc,
  input  logic          wr_valid,
  output logic [AW-1:0] addr_o,
  output logic          auto_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          auto_q, auto_d;
  logic [AW-1:0] lim;

  always_comb begin
    lim    = AW'(last_digit(cfg_sixteen, DEPTH));
    addr_d = addr_q;
    auto_d = auto_q;
    if (cmd_valid) begin
      addr_d = cfg_sixteen ? cmd_addr : {1'b0, cmd_addr[AW-2:0]};
      auto_d = cmd_autoinc;
    end else if (wr_valid && entry_mode == ENTRY_LEFT && auto_q) begin
      addr_d = (addr_q >= lim) ? '0 : addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      auto_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      auto_q <= auto_d;
    end
  end

  assign addr_o = addr_q;
  assign auto_o = auto_q;
endmodule

// File: rtl/disp_ram.sv
module disp_ram
  import disp_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int NIB_W = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = 2 * NIB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sixteen,
  input  entry_e        entry_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          keep_hi,
  input  logic          keep_lo,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0]    ram_q [DEPTH];
  logic [DW-1:0]    ram_d [DEPTH];
  logic [DEPTH-1:0] ent_en;
  int               lim;

  always_comb begin
    lim = last_digit(cfg_sixteen, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      ram_d[i]  = ram_q[i];
      ent_en[i] = 1'b0;
    end
    if (wr_en) begin
      if (entry_mode == ENTRY_RIGHT) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (i < lim) begin
            ram_d[i]  = ram_q[i+1];
            ent_en[i] = 1'b1;
          end
        end
        ram_d[lim]  = wr_data;
        ent_en[lim] = 1'b1;
      end else begin
        if (!keep_hi) ram_d[wr_addr][DW-1:NIB_W] = wr_data[DW-1:NIB_W];
        if (!keep_lo) ram_d[wr_addr][NIB_W-1:0]  = wr_data[NIB_W-1:0];
        ent_en[wr_addr] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_en[i]) ram_q[i] <= ram_d[i];
      end
    end
  end

  assign rd_data = ram_q[rd_idx];
endmodule

// File: rtl/disp_scan.sv
module disp_scan
  import disp_pkg::*;
#(
  parameter  int DEPTH     = 16,
  parameter  int DWELL     = 8,
  parameter  int BLANK_CYC = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int PW        = $clog2(DWELL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sixteen,
  output logic [AW-1:0] digit_o,
  output logic          blank_o
);
  logic [PW-1:0] phase_q, phase_d;
  logic [AW-1:0] digit_q, digit_d;
  logic [AW-1:0] lim;
  logic          period_end;

  always_comb begin
    lim        = AW'(last_digit(cfg_sixteen, DEPTH));
    period_end = (phase_q == PW'(DWELL - 1));
    phase_d    = period_end ? '0 : phase_q + 1'b1;
    digit_d    = digit_q;
    if (period_end) digit_d = (digit_q >= lim) ? '0 : digit_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      digit_q <= '0;
    end else begin
      phase_q <= phase_d;
      digit_q <= digit_d;
    end
  end

  assign blank_o = (phase_q < PW'(BLANK_CYC)) || (phase_q >= PW'(DWELL - BLANK_CYC));
  assign digit_o = digit_q;
endmodule

// File: rtl/disp_refresh.sv
module disp_refresh
  import disp_pkg::*;
#(
  parameter  int DEPTH     = 16,
  parameter  int NIB_W     = 4,
  parameter  int DWELL     = 8,
  parameter  int BLANK_CYC = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int DW        = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sixteen,
  input  logic             cfg_right,
  input  logic [DW-1:0]    blank_code,
  input  logic             cmd_valid,
  input  logic [AW-1:0]    cmd_addr,
  input  logic             cmd_autoinc,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_keep_hi,
  input  logic             wr_keep_lo,
  output logic [AW-1:0]    scan_o,
  output logic             blank_o,
  output logic [NIB_W-1:0] out_a,
  output logic [NIB_W-1:0] out_b
);
  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  entry_e        entry_mode;
  logic [AW-1:0] cur_addr;
  logic          cur_auto;
  logic          wr_take;
  logic [AW-1:0] digit;
  logic          blank;
  logic [DW-1:0] glyph;
  logic [DW-1:0] shown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign entry_mode = entry_e'(cfg_right);
  assign wr_take    = wr_valid && !cmd_valid;

  disp_addr #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_sync_n), .cfg_sixteen(cfg_sixteen),
    .entry_mode(entry_mode), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_autoinc(cmd_autoinc), .wr_valid(wr_valid),
    .addr_o(cur_addr), .auto_o(cur_auto)
  );

  disp_ram #(.DEPTH(DEPTH), .NIB_W(NIB_W)) u_ram (
    .clk(clk), .rst_n(rst_sync_n), .cfg_sixteen(cfg_sixteen),
    .entry_mode(entry_mode), .wr_en(wr_take), .wr_addr(cur_addr),
    .wr_data(wr_data), .keep_hi(wr_keep_hi), .keep_lo(wr_keep_lo),
    .rd_idx(digit), .rd_data(glyph)
  );

  disp_scan #(.DEPTH(DEPTH), .DWELL(DWELL), .BLANK_CYC(BLANK_CYC)) u_scan (
    .clk(clk), .rst_n(rst_sync_n), .cfg_sixteen(cfg_sixteen),
    .digit_o(digit), .blank_o(blank)
  );

  assign shown   = blank ? blank_code : glyph;
  assign out_a   = shown[DW-1:NIB_W];
  assign out_b   = shown[NIB_W-1:0];
  assign scan_o  = digit;
  assign blank_o = blank;
endmodule

// File: rtl/disp_refresh_chk.sv
module disp_refresh_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_i_n,
  input logic          cfg_sixteen,
  input logic          cfg_right,
  input logic          cmd_valid,
  input logic [AW-1:0] cmd_addr,
  input logic          wr_valid,
  input logic [AW-1:0] scan_o,
  input logic          blank_o,
  input logic [AW-1:0] cur_addr,
  input logic          cur_auto
);
  logic armed;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  // R2: the index only steps by one or returns to zero
  p_scan_step_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (armed && scan_o != $past(scan_o)) |-> (scan_o == $past(scan_o) + 1'b1 || scan_o == '0));

  // R3: a digit change is blanked on both sides of the edge
  p_blank_edge_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (armed && scan_o != $past(scan_o)) |-> (blank_o && $past(blank_o)));

  // R6: a command sets the pointer, bit 3 cleared in 8-digit mode
  p_cmd_load_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (armed && $past(cmd_valid)) |->
      cur_addr == ($past(cfg_sixteen) ? $past(cmd_addr) : {1'b0, $past(cmd_addr[AW-2:0])}));

  // R7: pointer advances after a left-placed write with advance on
  p_autoinc_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (armed && $past(wr_valid && !cmd_valid && !cfg_right && cur_auto)) |->
      (cur_addr == $past(cur_addr) + 1'b1 || cur_addr == '0));

  // R9: right-placed writes leave the pointer alone
  p_right_hold_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (armed && $past(wr_valid && !cmd_valid && cfg_right)) |-> cur_addr == $past(cur_addr));
endmodule

bind disp_refresh disp_refresh_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_i_n(rst_sync_n), .cfg_sixteen(cfg_sixteen), .cfg_right(cfg_right),
  .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .wr_valid(wr_valid),
  .scan_o(scan_o), .blank_o(blank_o), .cur_addr(cur_addr), .cur_auto(cur_auto)
);

// File: tb/disp_refresh_tb.sv
`timescale 1ns/1ps
module disp_refresh_tb;
  localparam int DEPTH = 16, DWELL = 8, BLK = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_sixteen, cfg_right;
  logic [7:0] blank_code;
  logic       cmd_valid, cmd_autoinc, wr_valid, wr_keep_hi, wr_keep_lo;
  logic [3:0] cmd_addr;
  logic [7:0] wr_data;
  logic [3:0] scan_o, out_a, out_b;
  logic       blank_o;

  always #5 clk = ~clk;

  disp_refresh u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sixteen(cfg_sixteen), .cfg_right(cfg_right),
    .blank_code(blank_code), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_autoinc(cmd_autoinc), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_keep_hi(wr_keep_hi), .wr_keep_lo(wr_keep_lo),
    .scan_o(scan_o), .blank_o(blank_o), .out_a(out_a), .out_b(out_b)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done  = 0;
  string tag   = "R5";

  // reference model state
  logic [7:0] m_ram [DEPTH];
  int         ph, dg, sy;
  logic [3:0] maddr;
  logic       mauto;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=0x%0h expected=0x%0h", req, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_ram[i] = 8'h00;
    ph = 0; dg = 0; sy = 0; maddr = 4'd0; mauto = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit   eb;
      logic [7:0] ew;
      int   lim;
      if (!rst_n) model_reset();
      eb = (ph < BLK) || (ph >= DWELL - BLK);
      ew = eb ? blank_code : m_ram[dg];
      check(scan_o == 4'(dg), (!rst_n || sy < 2) ? "R1" : "R2", scan_o, dg);
      check(blank_o == eb, (!rst_n || sy < 2) ? "R1" : "R3", blank_o, eb);
      check({out_a, out_b} == ew, (!rst_n || sy < 2) ? "R1" : (eb ? "R4" : tag),
            {out_a, out_b}, ew);
      if (rst_n) begin
        if (sy < 2) sy++;
        else begin
          lim = cfg_sixteen ? DEPTH - 1 : DEPTH / 2 - 1;
          if (cmd_valid) begin
            maddr = cfg_sixteen ? cmd_addr : {1'b0, cmd_addr[2:0]};
            mauto = cmd_autoinc;
          end else if (wr_valid) begin
            if (cfg_right) begin
              for (int i = 0; i < lim; i++) m_ram[i] = m_ram[i+1];
              m_ram[lim] = wr_data;
            end else begin
              if (!wr_keep_hi) m_ram[maddr][7:4] = wr_data[7:4];
              if (!wr_keep_lo) m_ram[maddr][3:0] = wr_data[3:0];
              if (mauto) maddr = (int'(maddr) >= lim) ? 4'd0 : maddr + 4'd1;
            end
          end
          if (ph == DWELL - 1) begin
            ph = 0;
            dg = (dg >= lim) ? 0 : dg + 1;
          end else ph++;
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_addr(input logic [3:0] a, input logic ai);
    cmd_valid = 1'b1; cmd_addr = a; cmd_autoinc = ai;
    tick(1);
    cmd_valid = 1'b0;
  endtask

  task automatic put(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    tick(1);
    wr_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_sixteen = 1'b1; cfg_right = 1'b0; blank_code = 8'h00;
    cmd_valid = 1'b0; cmd_addr = '0; cmd_autoinc = 1'b0;
    wr_valid = 1'b0; wr_data = '0; wr_keep_hi = 1'b0; wr_keep_lo = 1'b0;
    tick(4);                      // R1 checked while held in reset
    rst_n = 1'b1;
    tick(6);

    // R7: advancing writes over all 16 entries, then wrap to 0
    tag = "R7";
    load_addr(4'd0, 1'b1);
    for (int i = 0; i < DEPTH; i++) put(8'(i * 17 + 3));
    put(8'hA5);
    tick(2 * DEPTH * DWELL);

    // R7: advance off, repeated writes hit one entry
    load_addr(4'd5, 1'b0);
    put(8'h11);
    put(8'h22);
    tick(DEPTH * DWELL);

    // R2: drop to 8 digits while the scan is in the upper half
    tag = "R2";
    wait (scan_o == 4'd11);
    tick(3);
    cfg_sixteen = 1'b0;
    tick(3 * 8 * DWELL);

    // R6: bit 3 of the pointer cleared in 8-digit mode
    tag = "R6";
    load_addr(4'hC, 1'b1);
    put(8'h3C);
    put(8'h3D);
    tick(8 * DWELL);

    // R4: non-zero blank code
    blank_code = 8'h5A;
    tag = "R4";
    tick(8 * DWELL);

    // R8: nibble keeps in left-placed entry
    tag = "R8";
    load_addr(4'd1, 1'b0);
    wr_keep_hi = 1'b1; put(8'hF0);
    wr_keep_hi = 1'b0; wr_keep_lo = 1'b1; put(8'h9E);
    wr_keep_lo = 1'b0;
    tick(8 * DWELL);

    // R9: right-placed entry in 8-digit mode, keeps have no effect
    tag = "R9";
    cfg_right = 1'b1;
    for (int i = 0; i < 10; i++) begin
      wr_keep_hi = i[0];
      put(8'(8'hC0 + i));
    end
    wr_keep_hi = 1'b0;
    tick(8 * DWELL);
    cfg_sixteen = 1'b1;
    put(8'hE1); put(8'hE2); put(8'hE3);
    tick(DEPTH * DWELL);

    // R6: command and write in the same cycle, write dropped
    tag = "R6";
    cfg_right = 1'b0;
    load_addr(4'd2, 1'b0);
    cmd_valid = 1'b1; cmd_addr = 4'd9; cmd_autoinc = 1'b0;
    wr_valid = 1'b1; wr_data = 8'h77;
    tick(1);
    cmd_valid = 1'b0; wr_valid = 1'b0;
    put(8'h66);
    tick(DEPTH * DWELL);

    // R5: direct load of every address with its own value
    tag = "R5";
    blank_code = 8'h00;
    for (int a = 0; a < DEPTH; a++) begin
      load_addr(4'(a), 1'b0);
      put(8'(8'hFF - a * 13));
    end
    tick(2 * DEPTH * DWELL);

    finish_run();
  end
endmodule